// File: doc/BRIEF.md
# SDRAM Column Burst Sequencer

This block models the column side of a synchronous DRAM burst. A command input carries read, write or stop requests together with a start column. For every clock of an active burst the block emits the column it addresses. Write data is stored into a small column memory on the same clock edge as the beat that addresses it. Read data comes back from that memory after a selectable latency of two or three clocks.

The burst length is chosen per command: 2, 4, 8 or a whole page. Fixed lengths step through their aligned column block and wrap around inside it. A page burst steps through the whole row and wraps from the top column back to zero, and it only stops on a stop command. Any new read or write replaces the running burst at once. A write also blanks read data that is still in flight, so that read data cannot collide with the write on the shared data bus.

Top module: `sdram_burst_seq`

## Requirements
- R1: With a read command sampled at clock edge n, the first read word is presented after edge n+CL-1, so that it is captured at edge n+CL. CL is 2 when `cl3_i`=0 and 3 when `cl3_i`=1. The later words follow on consecutive clocks. `rvalid_o` is low at all other times.
- R2: A read sampled while a read burst runs ends the earlier burst at that edge. The words of the earlier burst that were already addressed still come out, and the new burst's words follow them with no idle clock between.
- R3: A write command (`cmd_i`=2) stores `wdata_i` into the start column on the edge that samples the command. Each later beat stores into the next column of the sequence, on consecutive clocks.
- R4: A write sampled during a write burst ends the earlier burst at that edge. From that edge on, the data goes to the new burst's columns.
- R5: A read (`cmd_i`=1) sampled during a write burst ends the write at that edge. The write data presented on that clock and on later clocks is not stored.
- R6: For lengths 2, 4 and 8 (`blen_i`=0, 1, 2), the column increases by one within the aligned block of that size and wraps to the block base. The burst ends after exactly that many beats. Data presented after the end is not stored.
- R7: For page length (`blen_i`=3), the column increases by one modulo the page size. The burst keeps running past the page size until a stop is sampled.
- R8: A stop command (`cmd_i`=3) sampled at edge t during a read burst means no column is addressed from edge t onward. The last word comes out after edge t+CL-2, and `rvalid_o` is low after edge t+CL-1.
- R9: A stop sampled during a write burst stores nothing from that edge onward. On the next clock with no command, no beat is active.
- R10: A write command sampled at edge w discards every read word still pending. `rvalid_o` is low after edge w.
- R11: When `wmask_i` is high on a write beat, that beat leaves its column unchanged. The burst still advances.
- R12: While reset is asserted and after its release with no command, `rvalid_o` and `beat_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | 0 idle, 1 read, 2 write, 3 stop |
| col_i | input | COL_W | Start column, sampled with a read or write |
| blen_i | input | 2 | Burst length for the command: 0=2, 1=4, 2=8, 3=page |
| cl3_i | input | 1 | Read latency: 0 gives 2 clocks, 1 gives 3 clocks |
| wdata_i | input | DW | Write data of the current beat |
| wmask_i | input | 1 | Blocks storage of the current write beat |
| beat_vld_o | output | 1 | A column is addressed in this clock |
| beat_wr_o | output | 1 | The addressed beat is a write |
| beat_col_o | output | COL_W | Column addressed in this clock |
| rvalid_o | output | 1 | Read word present on `rdata_o` |
| rdata_o | output | DW | Read word |

## Verification
The bound checker watches four things on every cycle. It checks the read latency for both settings whenever no write intervenes. It checks that a page burst's column steps by one from beat to beat. It checks that no beat follows a stop, and that read data is blanked right after a write. The bench covers what needs knowledge of the stored contents. It sweeps every start column for each fixed length and latency, reading back what was written. Its targeted scenarios show that interrupted or stopped writes do not store, that masked beats do not store, and how two read bursts join up.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_STOP = 2'd3
  } sdb_cmd_e;

  typedef enum logic [1:0] {
    BLEN_2    = 2'd0,
    BLEN_4    = 2'd1,
    BLEN_8    = 2'd2,
    BLEN_PAGE = 2'd3
  } sdb_blen_e;
endpackage

// File: rtl/sdb_colgen.sv
module sdb_colgen
  import sdb_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sdb_cmd_e         cmd,
  input  logic [COL_W-1:0] col_i,
  input  sdb_blen_e        blen_i,
  output logic             beat_vld,
  output logic             beat_wr,
  output logic [COL_W-1:0] beat_col,
  output sdb_blen_e        mode_o
);
  localparam int CNT_W = COL_W + 1;

  // next column: increment inside the aligned block (page: whole row)
  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input sdb_blen_e m);
    logic [COL_W-1:0] msk;
    logic [COL_W-1:0] inc;
    inc = c + 1'b1;
    case (m)
      BLEN_2:  msk = COL_W'(1);
      BLEN_4:  msk = COL_W'(3);
      BLEN_8:  msk = COL_W'(7);
      default: msk = '1;
    endcase
    return (c & ~msk) | (inc & msk);
  endfunction

  function automatic logic [CNT_W-1:0] beats_m1(input sdb_blen_e m);
    case (m)
      BLEN_2:  return CNT_W'(1);
      BLEN_4:  return CNT_W'(3);
      BLEN_8:  return CNT_W'(7);
      default: return '0;
    endcase
  endfunction

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [CNT_W-1:0] left_q, left_d;
  sdb_blen_e        mode_q, mode_d;
  logic             new_cmd;
  logic             upd_en;

  assign new_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    col_d  = col_q;
    left_d = left_q;
    mode_d = mode_q;
    upd_en = (cmd != CMD_NOP) || act_q;
    if (new_cmd) begin
      act_d  = 1'b1;
      wr_d   = (cmd == CMD_WR);
      col_d  = step_col(col_i, blen_i);
      left_d = beats_m1(blen_i);
      mode_d = blen_i;
    end else if (cmd == CMD_STOP) begin
      act_d = 1'b0;
    end else if (act_q) begin
      col_d = step_col(col_q, mode_q);
      if (mode_q != BLEN_PAGE) begin
        left_d = left_q - 1'b1;
        if (left_q == CNT_W'(1)) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      col_q  <= '0;
      left_q <= '0;
      mode_q <= BLEN_2;
    end else if (upd_en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      col_q  <= col_d;
      left_q <= left_d;
      mode_q <= mode_d;
    end
  end

  assign beat_vld = new_cmd || (act_q && (cmd == CMD_NOP));
  assign beat_wr  = new_cmd ? (cmd == CMD_WR) : wr_q;
  assign beat_col = new_cmd ? col_i : col_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/sdb_store.sv
module sdb_store #(
  parameter int COL_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [COL_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [COL_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << COL_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sdb_rdpipe.sv
module sdb_rdpipe #(
  parameter int COL_W  = 4,
  parameter int DW     = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [COL_W-1:0] issue_col,
  input  logic             flush,
  input  logic             cl3,
  output logic [COL_W-1:0] raddr,
  input  logic [DW-1:0]    rdata,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int NSTG = MAX_CL - 1;

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    logic             v_q;
    logic [COL_W-1:0] c_q;
    logic             vin;
    logic [COL_W-1:0] cin;
    if (k == 0) begin : g_head
      assign vin = issue;
      assign cin = issue_col;
    end else begin : g_body
      assign vin = g_stg[k-1].v_q;
      assign cin = g_stg[k-1].c_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else begin
        v_q <= vin && !flush;
        if (vin) c_q <= cin;
      end
    end
  end

  logic tap_vld;
  logic rv_q;
  logic [DW-1:0] rd_q;

  assign tap_vld = cl3 ? g_stg[1].v_q : g_stg[0].v_q;
  assign raddr   = cl3 ? g_stg[1].c_q : g_stg[0].c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= tap_vld && !flush;
      if (tap_vld && !flush) rd_q <= rdata;
    end
  end

  assign rvalid_o = rv_q;
  assign rdata_o  = rd_q;
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdb_pkg::*;
#(
  parameter int COL_W  = 4,
  parameter int DW     = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blen_i,
  input  logic             cl3_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wmask_i,
  output logic             beat_vld_o,
  output logic             beat_wr_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o
);
  sdb_cmd_e         cmd_e;
  sdb_blen_e        blen_e;
  sdb_blen_e        blen_act;
  logic             store_we;
  logic [COL_W-1:0] rd_addr;
  logic [DW-1:0]    rd_word;

  assign cmd_e  = sdb_cmd_e'(cmd_i);
  assign blen_e = sdb_blen_e'(blen_i);

  sdb_colgen #(.COL_W(COL_W)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_e),
    .col_i    (col_i),
    .blen_i   (blen_e),
    .beat_vld (beat_vld_o),
    .beat_wr  (beat_wr_o),
    .beat_col (beat_col_o),
    .mode_o   (blen_act)
  );

  assign store_we = beat_vld_o && beat_wr_o && !wmask_i;

  sdb_store #(.COL_W(COL_W), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (store_we),
    .waddr (beat_col_o),
    .wdata (wdata_i),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  sdb_rdpipe #(.COL_W(COL_W), .DW(DW), .MAX_CL(MAX_CL)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (beat_vld_o && !beat_wr_o),
    .issue_col (beat_col_o),
    .flush     (cmd_e == CMD_WR),
    .cl3       (cl3_i),
    .raddr     (rd_addr),
    .rdata     (rd_word),
    .rvalid_o  (rvalid_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int COL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd_i,
  input logic             cl3_i,
  input logic             beat_vld_o,
  input logic             beat_wr_o,
  input logic [COL_W-1:0] beat_col_o,
  input logic             rvalid_o,
  input logic [1:0]       mode
);
  logic rd_issue;
  assign rd_issue = beat_vld_o && !beat_wr_o;

  AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cl3_i) && $past(rd_issue, 2) && ($past(cmd_i) != 2'd2)) |-> rvalid_o); // R1

  AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cl3_i) && $past(cl3_i, 2) && $past(rd_issue, 3) &&
     ($past(cmd_i) != 2'd2) && ($past(cmd_i, 2) != 2'd2)) |-> rvalid_o); // R1

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd3) && (cmd_i == 2'd0) && beat_vld_o && $past(beat_vld_o))
      |-> (beat_col_o == $past(beat_col_o) + 1'b1)); // R7

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cmd_i) == 2'd3) && (cmd_i == 2'd0)) |-> !beat_vld_o); // R9

  AST_WR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_i) == 2'd2) |-> !rvalid_o); // R10
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_i      (cmd_i),
  .cl3_i      (cl3_i),
  .beat_vld_o (beat_vld_o),
  .beat_wr_o  (beat_wr_o),
  .beat_col_o (beat_col_o),
  .rvalid_o   (rvalid_o),
  .mode       (blen_act)
);

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int NC = 1 << CW;
  localparam logic [1:0] C_NOP = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_STOP = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cmd;
  logic [CW-1:0] col;
  logic [1:0]    blen;
  logic          cl3;
  logic [DW-1:0] wd;
  logic          wm;
  logic          beat_vld, beat_wr, rvalid;
  logic [CW-1:0] beat_col;
  logic [DW-1:0] rdata;

  logic [DW-1:0] refm [NC];
  int  errs = 0;
  int  chks = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_seq #(.COL_W(CW), .DW(DW), .MAX_CL(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .col_i(col), .blen_i(blen),
    .cl3_i(cl3), .wdata_i(wd), .wmask_i(wm), .beat_vld_o(beat_vld),
    .beat_wr_o(beat_wr), .beat_col_o(beat_col), .rvalid_o(rvalid),
    .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] nxt(input logic [CW-1:0] c, input int bl);
    int ci;
    int b;
    ci = int'(c);
    if (bl == 3) return CW'(ci + 1);
    b = 2 << bl;
    return CW'((ci & ~(b - 1)) | ((ci + 1) & (b - 1)));
  endfunction

  function automatic logic [DW-1:0] pat(input int c, input int s);
    return DW'(c * 29 + s * 11 + 3);
  endfunction

  // write burst of nb beats; masked beat index mb; ends with stop or idle
  task automatic wr_burst(input int start, input int nb, input int seed,
                          input bit stop, input int mb);
    logic [CW-1:0] c;
    c = CW'(start);
    for (int j = 0; j < nb; j++) begin
      @(negedge clk);
      cmd = (j == 0) ? C_WR : C_NOP;
      col = CW'(start);
      wd  = pat(int'(c), seed);
      wm  = (j == mb);
      #1 chk(beat_vld && beat_wr && (beat_col == c), "R3 column", int'(beat_col), int'(c));
      if (j != mb) refm[c] = wd;
      c = nxt(c, int'(blen));
    end
    @(negedge clk);
    cmd = stop ? C_STOP : C_NOP;
    wd  = 8'hA5;
    wm  = 1'b0;
    #1 chk(!beat_vld, stop ? "R9 beat after stop" : "R6 beat after end", int'(beat_vld), 0);
    @(negedge clk);
    cmd = C_NOP;
    #1 chk(!beat_vld, "R6 idle", int'(beat_vld), 0);
  endtask

  // read burst; page mode stops after nb beats
  task automatic rd_burst(input int start, input int nb, input string req);
    logic [CW-1:0] c;
    int lat;
    c = CW'(start);
    lat = cl3 ? 3 : 2;
    @(negedge clk);
    cmd = C_RD;
    col = CW'(start);
    #1 chk(beat_vld && !beat_wr && (beat_col == CW'(start)), req, int'(beat_col), start);
    for (int i = 1; i <= lat + nb; i++) begin
      @(negedge clk);
      cmd = (blen == 2'd3 && i == nb) ? C_STOP : C_NOP;
      #1;
      if (i < lat) chk(!rvalid, "R1 early data", int'(rvalid), 0);
      else if (i < lat + nb) begin
        chk(rvalid && (rdata == refm[c]), req, int'(rdata), int'(refm[c]));
        c = nxt(c, int'(blen));
      end else chk(!rvalid, req, int'(rvalid), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cmd = C_NOP; col = '0; blen = 2'd0; cl3 = 1'b0; wd = '0; wm = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rvalid && !beat_vld, "R12 in reset", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!rvalid && !beat_vld, "R12 after reset", int'(beat_vld), 0);

    // fill whole page
    blen = 2'd3;
    wr_burst(0, NC, 0, 1'b1, -1);

    // sweep fixed lengths, latencies and all start columns
    for (int cl = 0; cl < 2; cl++)
      for (int bl = 0; bl < 3; bl++)
        for (int s = 0; s < NC; s++) begin
          blen = 2'(bl);
          cl3  = cl[0];
          wr_burst(s, 2 << bl, s + bl * 16 + cl * 64, 1'b0, -1);
          rd_burst(s, 2 << bl, "R1/R6 read back");
        end

    // page wrap, page stop on reads
    for (int cl = 0; cl < 2; cl++) begin
      blen = 2'd3;
      cl3  = cl[0];
      wr_burst(5, NC + 3, 77 + cl, 1'b1, -1);
      rd_burst(5, NC, "R7 page wrap");
      rd_burst(9, NC + 5, "R7 page run");
      rd_burst(2, 5, "R8 read stop");
    end

    // stop during a write
    cl3 = 1'b0;
    blen = 2'd3;
    wr_burst(0, 5, 200, 1'b1, -1);
    rd_burst(0, NC, "R9 stopped write");

    // masked beat
    blen = 2'd1;
    wr_burst(8, 4, 300, 1'b0, 2);
    rd_burst(8, 4, "R11 masked beat");

    // read joined by read
    for (int cl = 0; cl < 2; cl++) begin
      int lat;
      cl3 = cl[0];
      lat = cl3 ? 3 : 2;
      for (int i = 0; i <= lat + 6; i++) begin
        @(negedge clk);
        cmd = (i == 0 || i == 2) ? C_RD : C_NOP;
        col = (i == 2) ? CW'(8) : CW'(0);
        #1;
        if (i == lat || i == lat + 1)
          chk(rvalid && rdata == refm[i - lat], "R2 first burst", int'(rdata), int'(refm[i - lat]));
        else if (i >= lat + 2 && i <= lat + 5)
          chk(rvalid && rdata == refm[8 + i - lat - 2], "R2 second burst", int'(rdata),
              int'(refm[8 + i - lat - 2]));
        else if (i == lat + 6)
          chk(!rvalid, "R2 end", int'(rvalid), 0);
      end
    end

    // write interrupted by write
    blen = 2'd1;
    cl3  = 1'b0;
    for (int i = 0; i < 6; i++) begin
      logic [CW-1:0] c;
      c = (i == 0) ? CW'(4) : CW'(11 + i);
      @(negedge clk);
      cmd = (i < 2) ? C_WR : C_NOP;
      col = c;
      wd  = pat(int'(c), 400);
      wm  = 1'b0;
      #1;
      if (i < 5) begin
        chk(beat_vld && beat_col == c, "R4 column", int'(beat_col), int'(c));
        refm[c] = wd;
      end else chk(!beat_vld, "R4 end", int'(beat_vld), 0);
    end
    rd_burst(4, 4, "R4 first write cut");
    rd_burst(12, 4, "R4 second write");

    // write interrupted by read
    cl3 = 1'b1;
    @(negedge clk);
    cmd = C_WR; col = CW'(4); wd = pat(4, 500);
    refm[4] = wd;
    @(negedge clk);
    cmd = C_RD; col = CW'(8); wd = 8'h3C;
    #1 chk(beat_vld && !beat_wr, "R5 read takes over", int'(beat_wr), 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmd = C_NOP; wd = 8'hC3;
    end
    rd_burst(4, 4, "R5 write data ignored");

    // write blanks pending read data
    cl3 = 1'b0;
    for (int i = 0; i <= 6; i++) begin
      logic [CW-1:0] c;
      c = (i == 1) ? CW'(3) : CW'(i - 2);
      @(negedge clk);
      cmd = (i == 0) ? C_RD : (i == 1) ? C_WR : C_NOP;
      col = (i == 0) ? CW'(0) : CW'(3);
      wd  = pat(int'(c), 600);
      #1;
      if (i >= 1 && i <= 4) refm[c] = wd;
      if (i >= 1) chk(!rvalid, "R10 blanked", int'(rvalid), 0);
    end
    rd_burst(0, 4, "R10 write stored");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      chks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule